// File: doc/BRIEF.md
# Address-Match Breakpoint with Pass Counter

This unit sits next to a small processor's 12-bit program address bus and stops execution at a chosen point. Software or an operator sets a search address from a bank of switches, then trims it up or down one location at a time. A small pass count says how many times execution may run through that address before the stop takes effect.

Every instruction fetch is compared with the search address. When the pass count has run out, the unit raises a sticky completion flag and a halt request. It can also be told to stop on the fetch that follows the matching one. A run selection overrides the whole search and lets the processor run freely.

The same unit drives the processor's single test input. A hold control gives a steady level. A push-button gives a clean one-cycle pulse.

Top module: `bkpt_unit`

## Requirements
- R1: One clock edge after `load_stb` is sampled high, `search_addr` equals the `sw_addr` value sampled at that edge. Load takes priority over increment and decrement.
- R2: `incr_stb` adds one to `search_addr` and `decr_stb` subtracts one, both modulo 4096, so 0xFFF+1 gives 0x000 and 0x000-1 gives 0xFFF. Increment takes priority over decrement.
- R3: Any load, increment or decrement re-arms the search:
  - `search_done` and `halt_req` are low after that edge;
  - the pass count is taken from `pass_set` at that edge;
  - a fetch sampled at that same edge is not counted.
- R4: A matching fetch is one with `fetch_vld` high and `fetch_addr` equal to `search_addr`.
  - With pass count N, the search completes on the (N+1)-th matching fetch after arming.
  - `search_done` and `halt_req` go high at the edge that samples that fetch.
  - Fetches that do not match, and cycles with `fetch_vld` low, change nothing.
- R5: If `next_opt` is high when the completing match is sampled, completion is deferred. It takes place at the next edge that samples `fetch_vld` high, whatever the fetch address.
- R6: While `run_sel` is high:
  - fetches are neither counted nor able to complete the search;
  - `halt_req` is low from the following edge onward;
  - `search_done` is not changed.
- R7: `search_done` stays high until the next re-arm or reset. `halt_req` is high only while `search_done` is high.
- R8: `test_out` is high whenever `hold_lvl` is high, with no clock delay.
- R9: A rising edge on `oneshot_btn` makes `test_out` high for exactly one cycle.
  - The pulse begins at the third clock edge after the rise is first sampled.
  - Keeping the button pressed gives no further pulse.
- R10: After reset:
  - `search_addr` is 0x000;
  - `search_done` and `halt_req` are low;
  - the unit is unarmed, so fetches of address 0 do not complete a search until the first re-arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_addr | input | 12 | Switch value for the search address |
| load_stb | input | 1 | Load the search address from `sw_addr` |
| incr_stb | input | 1 | Step the search address up by one |
| decr_stb | input | 1 | Step the search address down by one |
| pass_set | input | 4 | Number of passes allowed before stopping |
| run_sel | input | 1 | Run mode: overrides the search |
| next_opt | input | 1 | Stop on the fetch after the match |
| fetch_vld | input | 1 | Instruction fetch strobe |
| fetch_addr | input | 12 | Address of the fetch |
| hold_lvl | input | 1 | Steady level for the test line |
| oneshot_btn | input | 1 | Asynchronous push-button for a test pulse |
| halt_req | output | 1 | Request to stop the processor |
| search_done | output | 1 | Sticky search-complete flag |
| search_addr | output | 12 | Current search address |
| test_out | output | 1 | Processor test-line level |

## Verification
The results fall due at different points after a stimulus:
- address updates, re-arming and completion all appear one edge after the inputs that cause them;
- the halt clears one edge after run mode is selected;
- the hold level reaches `test_out` in the same cycle;
- the button pulse appears on the third edge after its rise and lasts one cycle.

The bench changes inputs one time unit after a rising edge and compares one time unit after the next rising edge. Each comparison therefore covers exactly one edge of effect. A bench-side model, stepped once per edge from the stated requirements, supplies the expected values. The button pulse is checked directly, cycle by cycle.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    // Operation applied to the search address at the next edge
    typedef enum logic [1:0] {
        OP_KEEP = 2'd0,
        OP_LOAD = 2'd1,
        OP_INC  = 2'd2,
        OP_DEC  = 2'd3
    } addr_op_e;

    // Progress of the search
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,   // not armed since reset
        PH_COUNT = 2'd1,   // counting matching fetches
        PH_PEND  = 2'd2,   // waiting for the fetch after the match
        PH_DONE  = 2'd3    // completed
    } phase_e;

endpackage

// File: rtl/bkpt_addr_reg.sv
module bkpt_addr_reg
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  addr_op_e          op,
    input  logic [ADDR_W-1:0] sw_val,
    output logic [ADDR_W-1:0] addr
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } areg_t;

    areg_t s_d, s_q;

    // Next value of the search address; the add and subtract wrap naturally
    always_comb begin
        s_d = s_q;
        unique case (op)
            OP_LOAD: s_d.addr = sw_val;
            OP_INC:  s_d.addr = s_q.addr + {{(ADDR_W-1){1'b0}}, 1'b1};
            OP_DEC:  s_d.addr = s_q.addr - {{(ADDR_W-1){1'b0}}, 1'b1};
            default: s_d.addr = s_q.addr;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign addr = s_q.addr;

endmodule

// File: rtl/bkpt_pass_ctl.sv
module bkpt_pass_ctl
    import bkpt_pkg::*;
#(
    parameter int PASS_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic [PASS_W-1:0] pass_set,
    input  logic              run_sel,
    input  logic              next_opt,
    input  logic              fetch_vld,
    input  logic              fetch_hit,
    output logic              done,
    output logic              halt
);

    typedef struct packed {
        phase_e            phase;
        logic [PASS_W-1:0] cnt;
        logic              halt;
    } pctl_t;

    localparam logic [PASS_W-1:0] CNT_ONE  = {{(PASS_W-1){1'b0}}, 1'b1};
    localparam logic [PASS_W-1:0] CNT_ZERO = '0;

    pctl_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (arm) begin
            // Re-arm: restart counting with a fresh pass count
            s_d.phase = PH_COUNT;
            s_d.cnt   = pass_set;
            s_d.halt  = 1'b0;
        end else if (run_sel) begin
            // Run mode overrides the search and drops any halt request
            s_d.halt = 1'b0;
        end else begin
            unique case (s_q.phase)
                PH_COUNT: begin
                    if (fetch_vld && fetch_hit) begin
                        if (s_q.cnt == CNT_ZERO) begin
                            if (next_opt) begin
                                s_d.phase = PH_PEND;
                            end else begin
                                s_d.phase = PH_DONE;
                                s_d.halt  = 1'b1;
                            end
                        end else begin
                            s_d.cnt = s_q.cnt - CNT_ONE;
                        end
                    end
                end
                PH_PEND: begin
                    if (fetch_vld) begin
                        s_d.phase = PH_DONE;
                        s_d.halt  = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.phase <= PH_IDLE;
            s_q.cnt   <= '0;
            s_q.halt  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign done = (s_q.phase == PH_DONE);
    assign halt = s_q.halt;

endmodule

// File: rtl/bkpt_test_line.sv
module bkpt_test_line #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_lvl,
    input  logic btn,
    output logic test_out
);

    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic                   pulse;
    } tline_t;

    tline_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.sync[0] = btn;
        // Shift the button through the synchroniser stages
        for (int i = 1; i < SYNC_STAGES; i++) begin
            s_d.sync[i] = s_q.sync[i-1];
        end
        s_d.prev  = s_q.sync[LAST];
        s_d.pulse = s_q.sync[LAST] & ~s_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign test_out = hold_lvl | s_q.pulse;

endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
    import bkpt_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int PASS_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] sw_addr,
    input  logic              load_stb,
    input  logic              incr_stb,
    input  logic              decr_stb,
    input  logic [PASS_W-1:0] pass_set,
    input  logic              run_sel,
    input  logic              next_opt,
    input  logic              fetch_vld,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              hold_lvl,
    input  logic              oneshot_btn,
    output logic              halt_req,
    output logic              search_done,
    output logic [ADDR_W-1:0] search_addr,
    output logic              test_out
);

    addr_op_e op;
    logic     arm;
    logic     fetch_hit;

    // Priority among the address strobes: load, then increment, then decrement
    always_comb begin
        if (load_stb)      op = OP_LOAD;
        else if (incr_stb) op = OP_INC;
        else if (decr_stb) op = OP_DEC;
        else               op = OP_KEEP;
    end

    assign arm       = (op != OP_KEEP);
    assign fetch_hit = (fetch_addr == search_addr);

    bkpt_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .sw_val (sw_addr),
        .addr   (search_addr)
    );

    bkpt_pass_ctl #(.PASS_W(PASS_W)) u_pass (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .pass_set  (pass_set),
        .run_sel   (run_sel),
        .next_opt  (next_opt),
        .fetch_vld (fetch_vld),
        .fetch_hit (fetch_hit),
        .done      (search_done),
        .halt      (halt_req)
    );

    bkpt_test_line #(.SYNC_STAGES(SYNC_STAGES)) u_test (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_lvl (hold_lvl),
        .btn      (oneshot_btn),
        .test_out (test_out)
    );

endmodule

// File: rtl/bkpt_unit_chk.sv
module bkpt_unit_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] sw_addr,
    input logic              load_stb,
    input logic              incr_stb,
    input logic              decr_stb,
    input logic              run_sel,
    input logic              fetch_vld,
    input logic              hold_lvl,
    input logic              halt_req,
    input logic              search_done,
    input logic [ADDR_W-1:0] search_addr,
    input logic              test_out
);

    logic [ADDR_W-1:0] addr_plus;
    logic [ADDR_W-1:0] addr_minus;
    logic              rearm;

    assign addr_plus  = search_addr + {{(ADDR_W-1){1'b0}}, 1'b1};
    assign addr_minus = search_addr - {{(ADDR_W-1){1'b0}}, 1'b1};
    assign rearm      = load_stb | incr_stb | decr_stb;

    assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> search_addr == $past(sw_addr));

    assert_incr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_stb && incr_stb) |=> search_addr == $past(addr_plus));

    assert_decr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_stb && !incr_stb && decr_stb) |=> search_addr == $past(addr_minus));

    assert_rearm_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rearm |=> (!search_done && !halt_req));

    assert_no_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!search_done && !fetch_vld) |=> !search_done);

    assert_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run_sel |=> !halt_req);

    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (search_done && !rearm) |=> search_done);

    assert_halt_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |-> search_done);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hold_lvl |-> test_out);

    assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (test_out && !hold_lvl) |=> (hold_lvl || !test_out));

endmodule

bind bkpt_unit bkpt_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_addr     (sw_addr),
    .load_stb    (load_stb),
    .incr_stb    (incr_stb),
    .decr_stb    (decr_stb),
    .run_sel     (run_sel),
    .fetch_vld   (fetch_vld),
    .hold_lvl    (hold_lvl),
    .halt_req    (halt_req),
    .search_done (search_done),
    .search_addr (search_addr),
    .test_out    (test_out)
);

// File: tb/bkpt_unit_tb.sv
module bkpt_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int RAND_CYCLES = 4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] sw_addr = '0;
    logic        load_stb = 0, incr_stb = 0, decr_stb = 0;
    logic [3:0]  pass_set = '0;
    logic        run_sel = 0, next_opt = 0, fetch_vld = 0;
    logic [11:0] fetch_addr = '0;
    logic        hold_lvl = 0, oneshot_btn = 0;
    logic        halt_req, search_done, test_out;
    logic [11:0] search_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // Reference state, stepped from the requirements
    logic [11:0] m_addr;
    logic [3:0]  m_cnt;
    bit          m_armed, m_pend, m_done, m_halt;

    always #(CLK_PERIOD/2) clk = ~clk;

    bkpt_unit u_dut (
        .clk(clk), .rst_n(rst_n), .sw_addr(sw_addr), .load_stb(load_stb),
        .incr_stb(incr_stb), .decr_stb(decr_stb), .pass_set(pass_set),
        .run_sel(run_sel), .next_opt(next_opt), .fetch_vld(fetch_vld),
        .fetch_addr(fetch_addr), .hold_lvl(hold_lvl), .oneshot_btn(oneshot_btn),
        .halt_req(halt_req), .search_done(search_done),
        .search_addr(search_addr), .test_out(test_out)
    );

    task automatic check(string tag, logic [11:0] act, logic [11:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [11:0] next_addr(logic [11:0] a);
        if (load_stb)      return sw_addr;
        else if (incr_stb) return a + 12'd1;
        else if (decr_stb) return a - 12'd1;
        return a;
    endfunction

    task automatic model_step();
        bit hit;
        hit = fetch_vld && (fetch_addr == m_addr);
        if (load_stb || incr_stb || decr_stb) begin          // R3
            m_armed = 1; m_pend = 0; m_done = 0; m_halt = 0; m_cnt = pass_set;
        end else if (run_sel) begin                          // R6
            m_halt = 0;
        end else if (m_armed && !m_done) begin
            if (m_pend) begin                                // R5
                if (fetch_vld) begin m_pend = 0; m_done = 1; m_halt = 1; end
            end else if (hit) begin                          // R4
                if (m_cnt == 0) begin
                    if (next_opt) m_pend = 1;
                    else begin m_done = 1; m_halt = 1; end
                end else m_cnt = m_cnt - 4'd1;
            end
        end
        m_addr = next_addr(m_addr);
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        #1;
    endtask

    task automatic quiet();
        load_stb = 0; incr_stb = 0; decr_stb = 0; fetch_vld = 0;
    endtask

    task automatic cmp_all(string tag);
        check({tag, " addr"}, search_addr, m_addr);
        check({tag, " done"}, {11'd0, search_done}, {11'd0, m_done});
        check({tag, " halt"}, {11'd0, halt_req}, {11'd0, m_halt});
        check({tag, " test"}, {11'd0, test_out}, {11'd0, hold_lvl});
    endtask

    task automatic fetch(logic [11:0] a);
        fetch_vld = 1; fetch_addr = a; tick(); fetch_vld = 0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'h5EED));
        m_addr = 0; m_cnt = 0; m_armed = 0; m_pend = 0; m_done = 0; m_halt = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R10: reset state, unarmed unit ignores fetches of address 0
        cmp_all("R10 reset");
        fetch(12'h000); fetch(12'h000);
        check("R10 unarmed done", {11'd0, search_done}, 12'd0);

        // R1: load, with priority over incr/decr
        sw_addr = 12'h3A5; load_stb = 1; incr_stb = 1; decr_stb = 1; pass_set = 0; tick(); quiet();
        check("R1 load", search_addr, 12'h3A5);

        // R2: wrap both ways
        sw_addr = 12'hFFF; load_stb = 1; tick(); quiet();
        incr_stb = 1; decr_stb = 1; tick(); quiet();
        check("R2 incr wrap", search_addr, 12'h000);
        decr_stb = 1; tick(); quiet();
        check("R2 decr wrap", search_addr, 12'hFFF);

        // R4: pass count 0 stops on first match, misses ignored
        sw_addr = 12'h100; pass_set = 0; load_stb = 1; tick(); quiet();
        fetch(12'h101);
        check("R4 miss ignored", {11'd0, search_done}, 12'd0);
        fetch(12'h100);
        check("R4 first match done", {11'd0, search_done}, 12'd1);
        check("R4 first match halt", {11'd0, halt_req}, 12'd1);
        // R7: sticky
        fetch(12'h055); tick();
        check("R7 sticky", {11'd0, search_done}, 12'd1);

        // R3 + R4: pass count 2 completes on third match
        pass_set = 2; sw_addr = 12'h200; load_stb = 1; tick(); quiet();
        check("R3 rearm clears done", {11'd0, search_done}, 12'd0);
        check("R3 rearm clears halt", {11'd0, halt_req}, 12'd0);
        fetch(12'h200); fetch(12'h200);
        check("R4 two passes not done", {11'd0, search_done}, 12'd0);
        fetch(12'h200);
        check("R4 third match done", {11'd0, search_done}, 12'd1);

        // R5: next-instruction option
        pass_set = 0; sw_addr = 12'h300; load_stb = 1; tick(); quiet();
        next_opt = 1; fetch(12'h300); next_opt = 0;
        check("R5 deferred", {11'd0, search_done}, 12'd0);
        tick();
        check("R5 idle wait", {11'd0, search_done}, 12'd0);
        fetch(12'h7C1);
        check("R5 next fetch done", {11'd0, search_done}, 12'd1);

        // R6: run override clears halt, keeps done; and blocks matches
        run_sel = 1; tick();
        check("R6 halt cleared", {11'd0, halt_req}, 12'd0);
        check("R6 done kept", {11'd0, search_done}, 12'd1);
        sw_addr = 12'h400; load_stb = 1; tick(); quiet();
        fetch(12'h400); fetch(12'h400);
        check("R6 no match in run", {11'd0, search_done}, 12'd0);
        run_sel = 0; fetch(12'h400);
        check("R6 match after run", {11'd0, search_done}, 12'd1);

        // R8: hold level
        hold_lvl = 1; #1;
        check("R8 hold high", {11'd0, test_out}, 12'd1);
        hold_lvl = 0; #1;
        check("R8 hold low", {11'd0, test_out}, 12'd0);

        // R9: one-shot pulse on third edge, one cycle, no repeat
        oneshot_btn = 1;
        tick(); check("R9 edge1", {11'd0, test_out}, 12'd0);
        tick(); check("R9 edge2", {11'd0, test_out}, 12'd0);
        tick(); check("R9 edge3 pulse", {11'd0, test_out}, 12'd1);
        tick(); check("R9 edge4 end", {11'd0, test_out}, 12'd0);
        repeat (5) begin tick(); check("R9 held no repeat", {11'd0, test_out}, 12'd0); end
        oneshot_btn = 0; repeat (4) tick();

        // Random mix against the reference model (R1..R8)
        for (int i = 0; i < RAND_CYCLES; i++) begin
            int r;
            r = $urandom_range(0, 99);
            load_stb = (r < 3);
            incr_stb = (r >= 3 && r < 5);
            decr_stb = (r >= 5 && r < 7) || (r == 8);
            sw_addr  = 12'($urandom_range(0, 4095));
            pass_set = 4'($urandom_range(0, 3));
            run_sel  = ($urandom_range(0, 99) < 5);
            next_opt = $urandom_range(0, 1) == 1;
            fetch_vld = ($urandom_range(0, 99) < 70);
            fetch_addr = ($urandom_range(0, 1) == 1) ? m_addr
                                                     : 12'(m_addr + 12'($urandom_range(0, 3)));
            hold_lvl = $urandom_range(0, 1) == 1;
            tick();
            cmp_all("R1-8 random");
        end
        quiet(); run_sel = 0; hold_lvl = 0;
        summary();
    end

endmodule